// File: doc/BRIEF.md
# Instruction Cache Valid-Bit Maintenance Sequencer

This block owns the write port of the valid-bit array of a set-associative instruction cache. It serves two kinds of maintenance work. A whole-cache invalidate is started by writing 1 to a control bit. The block then visits the sets in ascending order, clearing every way of one set per cycle. While it does this it holds the access pipeline stalled and shows a busy status bit. When the last set has been cleared, the status drops back to 0 on its own, with no software write. A single-line push names a set and a way, and clears that one valid bit.

A configuration level, the keep-valid control, turns line pushes into no-ops on the valid array. The line then stays valid. A push that arrives while a whole-cache walk is running is parked in a one-entry slot and issued in the first cycle after the walk ends. Reset touches only the sequencer's own state. It never writes the valid array, so the array keeps its contents until an invalidate command clears it.

Top module: `icache_maint_ctrl`

## Requirements
- R1: One cycle after a clock edge that samples `cfg_we_i`=1 with `cfg_inv_all_i`=1 while idle, `inv_busy_o` and `stall_o` are 1.
- R2: A control write with `cfg_inv_all_i`=0 starts nothing: `inv_busy_o` stays 0 and no valid-bit clear is issued.
- R3: During a walk, each cycle issues `vb_clr_o`=1 with all bits of `vb_way_mask_o` set. `vb_set_o` is 0 in the first walk cycle and rises by 1 each cycle.
- R4: A walk lasts exactly NUM_SETS cycles. `inv_busy_o` drops in the cycle after set NUM_SETS-1 is cleared.
- R5: `stall_o` is 1 in exactly the cycles where `inv_busy_o` is 1.
- R6: After reset `inv_busy_o`=0, `stall_o`=0 and `vb_clr_o`=0. Reset issues no valid-bit clear.
- R7: When idle, a push (`push_req_i`=1) with `cfg_keep_valid_i`=0 drives `vb_clr_o`=1 in the same cycle. `vb_set_o` equals `push_set_i`, and `vb_way_mask_o` has only bit `push_way_i` set.
- R8: A push with `cfg_keep_valid_i`=1 issues no clear (`vb_clr_o`=0), so the line stays valid.
- R9: A push that arrives during a walk causes no extra write during the walk. Its clear for the held set and way is issued in the first cycle after the walk.
- R10: An invalidate-all write during a walk is ignored. The walk neither restarts nor lengthens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_inv_all_i | input | 1 | Written value of the invalidate-all bit |
| cfg_keep_valid_i | input | 1 | 1: line pushes leave the valid bit set |
| push_req_i | input | 1 | Single-line push request |
| push_set_i | input | SET_W | Set index of the push |
| push_way_i | input | WAY_W | Way index of the push |
| vb_clr_o | output | 1 | Valid-array clear strobe |
| vb_set_o | output | SET_W | Set addressed by the clear |
| vb_way_mask_o | output | NUM_WAYS | Ways cleared in that set |
| stall_o | output | 1 | Holds off pipeline accesses |
| inv_busy_o | output | 1 | Readable invalidate-all status bit |

## Verification
The assertions assume that at most one push is outstanding. Once a push has been parked during a walk, no further push arrives until the parked one has issued. The bench respects this by issuing a single push inside each walk, and pushes after a walk only once the parked entry has drained. Control writes are one-cycle strobes, and the bench drives them only between clock edges, as the properties expect.

// File: rtl/icm_pkg.sv
package icm_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WALK = 1'b1
  } seq_state_e;
endpackage

// File: rtl/icm_walk_seq.sv
module icm_walk_seq #(
  parameter int NUM_SETS = 128,
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [SET_W-1:0] idx_o
);
  import icm_pkg::*;

  localparam logic [SET_W-1:0] LAST = SET_W'(NUM_SETS - 1);

  seq_state_e      state_q;
  logic [SET_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_WALK;
          idx_q   <= '0;
        end
        SEQ_WALK: begin
          if (idx_q == LAST) state_q <= SEQ_IDLE;
          else               idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == SEQ_WALK);
  assign idx_o  = idx_q;
endmodule

// File: rtl/icm_push_hold.sv
module icm_push_hold #(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             req_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAY_W-1:0] way_i,
  output logic             issue_o,
  output logic [SET_W-1:0] set_o,
  output logic [WAY_W-1:0] way_o
);
  logic             pend_q;
  logic [SET_W-1:0] pset_q;
  logic [WAY_W-1:0] pway_q;

  // park a push that meets a running walk; release it once idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      pset_q <= '0;
      pway_q <= '0;
    end else if (busy_i) begin
      if (req_i && !pend_q) begin
        pend_q <= 1'b1;
        pset_q <= set_i;
        pway_q <= way_i;
      end
    end else begin
      pend_q <= 1'b0;
    end
  end

  assign issue_o = !busy_i && (pend_q || req_i);
  assign set_o   = pend_q ? pset_q : set_i;
  assign way_o   = pend_q ? pway_q : way_i;
endmodule

// File: rtl/icache_maint_ctrl.sv
module icache_maint_ctrl #(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic                cfg_inv_all_i,
  input  logic                cfg_keep_valid_i,
  input  logic                push_req_i,
  input  logic [SET_W-1:0]    push_set_i,
  input  logic [WAY_W-1:0]    push_way_i,
  output logic                vb_clr_o,
  output logic [SET_W-1:0]    vb_set_o,
  output logic [NUM_WAYS-1:0] vb_way_mask_o,
  output logic                stall_o,
  output logic                inv_busy_o
);
  logic             walk_busy;
  logic [SET_W-1:0] walk_idx;
  logic             push_issue;
  logic [SET_W-1:0] push_set;
  logic [WAY_W-1:0] push_way;
  logic [NUM_WAYS-1:0] push_mask;

  icm_walk_seq #(.NUM_SETS(NUM_SETS)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cfg_we_i && cfg_inv_all_i),
    .busy_o  (walk_busy),
    .idx_o   (walk_idx)
  );

  icm_push_hold #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (walk_busy),
    .req_i   (push_req_i),
    .set_i   (push_set_i),
    .way_i   (push_way_i),
    .issue_o (push_issue),
    .set_o   (push_set),
    .way_o   (push_way)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_dec
    assign push_mask[w] = (push_way == WAY_W'(w));
  end

  always_comb begin
    if (walk_busy) begin
      vb_clr_o      = 1'b1;
      vb_set_o      = walk_idx;
      vb_way_mask_o = '1;
    end else begin
      vb_clr_o      = push_issue && !cfg_keep_valid_i;
      vb_set_o      = push_set;
      vb_way_mask_o = push_mask;
    end
  end

  assign stall_o    = walk_busy;
  assign inv_busy_o = walk_busy;
endmodule

// File: rtl/icache_maint_ctrl_chk.sv
module icache_maint_ctrl_chk #(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_we_i,
  input logic                cfg_inv_all_i,
  input logic                cfg_keep_valid_i,
  input logic                push_req_i,
  input logic [SET_W-1:0]    push_set_i,
  input logic [WAY_W-1:0]    push_way_i,
  input logic                vb_clr_o,
  input logic [SET_W-1:0]    vb_set_o,
  input logic [NUM_WAYS-1:0] vb_way_mask_o,
  input logic                stall_o,
  input logic                inv_busy_o
);
  localparam logic [SET_W-1:0] LAST = SET_W'(NUM_SETS - 1);

  p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_inv_all_i && !inv_busy_o |=> inv_busy_o && stall_o);

  p_zero_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !cfg_inv_all_i && !inv_busy_o |=> !inv_busy_o);

  p_walk_all_ways_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_busy_o |-> vb_clr_o && (&vb_way_mask_o));

  p_walk_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inv_busy_o) |-> vb_set_o == '0);

  p_walk_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_busy_o && $past(inv_busy_o) |-> vb_set_o == $past(vb_set_o) + 1'b1);

  p_walk_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_busy_o && vb_set_o == LAST |=> !inv_busy_o);

  p_stall_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o == inv_busy_o);

  p_push_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inv_busy_o && !$past(inv_busy_o) && push_req_i && !cfg_keep_valid_i
    |-> vb_clr_o && vb_set_o == push_set_i && $countones(vb_way_mask_o) == 1
        && vb_way_mask_o[push_way_i]);

  p_push_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inv_busy_o && !$past(inv_busy_o) && cfg_keep_valid_i |-> !vb_clr_o);
endmodule

bind icache_maint_ctrl icache_maint_ctrl_chk #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_chk (.*);

// File: tb/icache_maint_ctrl_test.sv
module icache_maint_ctrl_test;
  localparam int NUM_SETS = 128;
  localparam int NUM_WAYS = 4;
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_inv = 0, cfg_keep = 0, push_req = 0;
  logic [SET_W-1:0] push_set = '0;
  logic [WAY_W-1:0] push_way = '0;
  logic vb_clr, stall, busy;
  logic [SET_W-1:0] vb_set;
  logic [NUM_WAYS-1:0] vb_mask;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  icache_maint_ctrl #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_inv_all_i(cfg_inv),
    .cfg_keep_valid_i(cfg_keep), .push_req_i(push_req), .push_set_i(push_set),
    .push_way_i(push_way), .vb_clr_o(vb_clr), .vb_set_o(vb_set),
    .vb_way_mask_o(vb_mask), .stall_o(stall), .inv_busy_o(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  // {keep, set, way, exp_clr, exp_mask}
  typedef struct packed {
    logic             keep;
    logic [SET_W-1:0] set;
    logic [WAY_W-1:0] way;
    logic             clr;
    logic [NUM_WAYS-1:0] mask;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{1'b0, 7'd0,   2'd0, 1'b1, 4'b0001},
    '{1'b0, 7'd127, 2'd3, 1'b1, 4'b1000},
    '{1'b0, 7'd42,  2'd1, 1'b1, 4'b0010},
    '{1'b1, 7'd42,  2'd1, 1'b0, 4'b0010},
    '{1'b0, 7'd99,  2'd2, 1'b1, 4'b0100},
    '{1'b1, 7'd5,   2'd3, 1'b0, 4'b1000}
  };

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    chk("R6 clr in reset", vb_clr, 0);
    #20 rst_n = 1'b1;
    tick();
    chk("R6 busy after reset", busy, 0);
    chk("R6 stall after reset", stall, 0);
    chk("R6 clr after reset", vb_clr, 0);

    // push vectors, idle
    for (int i = 0; i < 6; i++) begin
      cfg_keep = VECS[i].keep; push_set = VECS[i].set; push_way = VECS[i].way;
      push_req = 1'b1;
      #1;
      chk(VECS[i].keep ? "R8 push keep clr" : "R7 push clr", vb_clr, VECS[i].clr);
      if (VECS[i].clr) begin
        chk("R7 push set", vb_set, VECS[i].set);
        chk("R7 push mask", vb_mask, VECS[i].mask);
      end
      tick();
      push_req = 1'b0; cfg_keep = 1'b0;
    end

    // write 0: nothing
    cfg_we = 1; cfg_inv = 0;
    tick();
    cfg_we = 0;
    chk("R2 busy after zero write", busy, 0);
    chk("R2 no clr after zero write", vb_clr, 0);

    // walk with push and re-trigger inside
    cfg_we = 1; cfg_inv = 1;
    tick();
    cfg_we = 0; cfg_inv = 0;
    chk("R1 busy after start", busy, 1);
    chk("R1 stall after start", stall, 1);
    begin
      int bad = 0;
      for (int i = 0; i < NUM_SETS; i++) begin
        if (i == 5) begin cfg_we = 1; cfg_inv = 1; end
        if (i == 10) begin push_req = 1; push_set = 7'd77; push_way = 2'd2; end
        #1;
        if (!(vb_clr && vb_set == SET_W'(i) && vb_mask == 4'hF && stall && busy)) bad++;
        tick();
        cfg_we = 0; cfg_inv = 0; push_req = 0;
      end
      chk("R3 walk order and masks", bad, 0);
    end
    chk("R4 busy drops after last set", busy, 0);
    chk("R10 walk not lengthened", stall, 0);
    chk("R5 stall drops with busy", stall, busy);
    chk("R9 held push clr", vb_clr, 1);
    chk("R9 held push set", vb_set, 77);
    chk("R9 held push mask", vb_mask, 4'b0100);
    tick();
    chk("R9 held push issued once", vb_clr, 0);

    // held push with keep set at issue -> no clear
    cfg_we = 1; cfg_inv = 1;
    tick();
    cfg_we = 0; cfg_inv = 0;
    push_req = 1; push_set = 7'd3; push_way = 2'd1;
    tick();
    push_req = 0;
    for (int i = 0; i < NUM_SETS - 1; i++) tick();
    cfg_keep = 1;
    #1;
    chk("R4 second walk ended", busy, 0);
    chk("R8 held push with keep", vb_clr, 0);
    tick();
    cfg_keep = 0;

    // reset again: no clear issued
    rst_n = 0;
    #1;
    chk("R6 no clr during reset", vb_clr, 0);
    chk("R6 busy during reset", busy, 0);
    tick();
    rst_n = 1;
    tick();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule